// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial link made of a bit clock, a frame clock that marks left and right, and a data line. Both link clocks come from an external source, so the block runs as a slave. It samples all three wires with its own system clock. It finds the rising edges of the bit clock and the level changes of the frame clock. A 3-bit format code picks the framing and the word length. The block then pulls the data word out of each half-frame.

Short words are moved to the top of a 24-bit sample and the low bits are filled with zeros. After the right-channel word of a frame is complete, the block shows both channels together and raises a valid strobe for one system clock. The outputs keep their values until the next strobe. Anything on the data line outside the selected word window does not reach the outputs.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high, `leftOut`, `rightOut` and `sampleValid` are zero. Asserting `rst` in the middle of operation clears the outputs.
- R2: `fmtCode` selects the framing as follows. 0 = LSB-justified 16-bit. 1 = LSB-justified 20-bit. 4 = LSB-justified 24-bit. 2 and 5 = MSB-justified 24-bit. 3 and 6 = I2S 24-bit. 7 = reserved.
- R3: In MSB-justified framing the MSB is the first bit sampled after a frame-clock change. A high frame clock marks the left channel.
- R4: In I2S framing the MSB is the second bit sampled after a frame-clock change. A low frame clock marks the left channel.
- R5: In LSB-justified framing the LSB is the last bit sampled before the frame clock changes. The word is the final 16, 20 or 24 bits of the half-frame.
- R6: 16-bit and 20-bit words appear in bits 23 and down of the output. All lower output bits are zero.
- R7: Data-line bits outside the word window have no effect on the outputs.
- R8: `sampleValid` is high for exactly one system clock per complete frame. It rises after the right word completes, which is when the frame clock next changes. Both channels update together, and neither output changes while `sampleValid` is low.
- R9: Format 0 works with 32 bit clocks per frame, that is 16 per half.
- R10: With code 7, no strobe is produced and the outputs keep their previous values.
- R11: A frame that is already in progress when reset is released produces no strobe. The first strobe comes only after a left half and a right half have each been received in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It must run well above the bit clock rate. |
| rst | input | 1 | Synchronous reset, active high |
| bitClk | input | 1 | Serial bit clock. Data is sampled on its rising edges. |
| frameClk | input | 1 | Frame clock. It marks the channel and the word boundary. |
| serData | input | 1 | Serial data in two's complement, sent MSB first |
| fmtCode | input | 3 | Framing and word-length select |
| leftOut | output | 24 | Left sample, left-aligned |
| rightOut | output | 24 | Right sample, left-aligned |
| sampleValid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench fills every bit outside the word window with random values or with all ones. A receiver with an off-by-one window would therefore pick up a junk bit, or lose the LSB or the MSB. The I2S tests check the one-bit delay and the inverted channel polarity together: if either is wrong, the expected pair comes out shifted by one bit or with left and right swapped. The short-word tests, including the 32-clock frame, would catch zero padding placed at the wrong end. A run that starts in the middle of a frame after reset, and a run with the reserved code, must both produce no strobe at all; a design that trusts the first edge, or that decodes code 7, would produce an extra pair.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    JUST_LSB  = 2'd0,
    JUST_MSB  = 2'd1,
    JUST_I2S  = 2'd2,
    JUST_NONE = 2'd3
  } justify_e;

  typedef enum logic [1:0] {
    LEN16 = 2'd0,
    LEN20 = 2'd1,
    LEN24 = 2'd2
  } wlen_e;

  typedef struct packed {
    logic  shiftEn;
    logic  bitVal;
    logic  takeLeft;
    logic  emitPair;
    wlen_e wordLen;
  } dpCtrl_t;

  function automatic justify_e fmtJustify(input logic [2:0] code);
    case (code)
      3'd0, 3'd1, 3'd4: fmtJustify = JUST_LSB;
      3'd2, 3'd5:       fmtJustify = JUST_MSB;
      3'd3, 3'd6:       fmtJustify = JUST_I2S;
      default:          fmtJustify = JUST_NONE;
    endcase
  endfunction

  function automatic wlen_e fmtLen(input logic [2:0] code);
    case (code)
      3'd0:    fmtLen = LEN16;
      3'd1:    fmtLen = LEN20;
      default: fmtLen = LEN24;
    endcase
  endfunction

  function automatic int lenBits(input wlen_e len);
    case (len)
      LEN16:   lenBits = 16;
      LEN20:   lenBits = 20;
      default: lenBits = 24;
    endcase
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= '0;
          else     chain[gi] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= '0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitClk,
  input  logic       frameClk,
  input  logic       serData,
  input  logic [2:0] fmtCode,
  output dpCtrl_t    dpCtl
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [2:0] syncBus;
  logic       bitS, frameS, dataS;

  srx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({bitClk, frameClk, serData}),
    .syncOut (syncBus)
  );

  assign {bitS, frameS, dataS} = syncBus;

  logic             bitPrev;
  logic             primed;
  logic             prevFrame;
  logic             seenEdge;
  logic             leftReady;
  logic [POS_W-1:0] bitPos;

  logic             bitRise;
  logic             frameEdge;
  logic [POS_W-1:0] curPos;
  justify_e         just;
  wlen_e            wlen;
  int               wordBits;
  int               winStart;
  logic             inWindow;
  logic             halfWasLeft;
  logic             finishHalf;

  always_comb begin
    bitRise     = bitS & ~bitPrev;
    frameEdge   = bitRise && primed && (frameS != prevFrame);
    curPos      = frameEdge ? '0 : bitPos;
    just        = fmtJustify(fmtCode);
    wlen        = fmtLen(fmtCode);
    wordBits    = lenBits(wlen);
    winStart    = (just == JUST_I2S) ? 1 : 0;
    if (just == JUST_LSB)
      inWindow = 1'b1;
    else
      inWindow = (int'(curPos) >= winStart) && (int'(curPos) < winStart + wordBits);
    halfWasLeft = (just == JUST_I2S) ? ~prevFrame : prevFrame;
    finishHalf  = frameEdge && seenEdge && (just != JUST_NONE);

    dpCtl.shiftEn  = bitRise && (just != JUST_NONE) && inWindow;
    dpCtl.bitVal   = dataS;
    dpCtl.takeLeft = finishHalf && halfWasLeft;
    dpCtl.emitPair = finishHalf && !halfWasLeft && leftReady;
    dpCtl.wordLen  = wlen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitPrev   <= 1'b0;
      primed    <= 1'b0;
      prevFrame <= 1'b0;
      seenEdge  <= 1'b0;
      leftReady <= 1'b0;
      bitPos    <= '0;
    end else begin
      bitPrev <= bitS;
      if (bitRise) begin
        primed    <= 1'b1;
        prevFrame <= frameS;
        if (frameEdge)
          bitPos <= {{(POS_W-1){1'b0}}, 1'b1};
        else if (bitPos != POS_MAX)
          bitPos <= bitPos + 1'b1;
        if (frameEdge)
          seenEdge <= 1'b1;
      end
      if (dpCtl.takeLeft)
        leftReady <= 1'b1;
      else if (finishHalf && !halfWasLeft)
        leftReady <= 1'b0;
    end
  end

  // R8: a synchronised bit-clock rise lasts one system cycle only
  p_single_rise_r8: assert property (@(posedge clk) disable iff (rst)
    bitRise |=> !bitRise)
    else $error("bit-clock rise detected on consecutive cycles");

  // R3: the bit position restarts after every frame-clock change
  p_pos_restart_r3: assert property (@(posedge clk) disable iff (rst)
    frameEdge |=> (bitPos == {{(POS_W-1){1'b0}}, 1'b1}))
    else $error("bit position did not restart on frame edge");

  // R11: nothing is completed before a first real frame edge
  p_no_early_finish_r11: assert property (@(posedge clk) disable iff (rst)
    (!seenEdge) |-> !(dpCtl.takeLeft || dpCtl.emitPair))
    else $error("half finished before any frame edge");

endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           dpCtl,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleValid
);

  logic [WORD_W-1:0] capReg;
  logic [WORD_W-1:0] leftHold;
  logic [WORD_W-1:0] alignedWord;
  int                padBits;

  always_comb begin
    padBits     = WORD_W - lenBits(dpCtl.wordLen);
    alignedWord = capReg << padBits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capReg      <= '0;
      leftHold    <= '0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= dpCtl.emitPair;
      if (dpCtl.shiftEn)
        capReg <= {capReg[WORD_W-2:0], dpCtl.bitVal};
      if (dpCtl.takeLeft)
        leftHold <= alignedWord;
      if (dpCtl.emitPair) begin
        leftOut  <= leftHold;
        rightOut <= alignedWord;
      end
    end
  end

  // R8: strobe is one cycle wide
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid)
    else $error("valid strobe longer than one cycle");

  // R8: outputs hold between strobes
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> ($stable(leftOut) && $stable(rightOut)))
    else $error("outputs changed without strobe");

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import srx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitClk,
  input  logic              frameClk,
  input  logic              serData,
  input  logic [2:0]        fmtCode,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleValid
);

  dpCtrl_t dpCtl;

  srx_ctrl #(.SYNC_STAGES(SYNC_STAGES), .POS_W(POS_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitClk   (bitClk),
    .frameClk (frameClk),
    .serData  (serData),
    .fmtCode  (fmtCode),
    .dpCtl    (dpCtl)
  );

  srx_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .dpCtl       (dpCtl),
    .leftOut     (leftOut),
    .rightOut    (rightOut),
    .sampleValid (sampleValid)
  );

  // R10: the reserved code never yields a strobe
  p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(fmtCode) == 3'd7) |-> !sampleValid)
    else $error("strobe under reserved format");

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_HALF   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitClk = 1'b0;
  logic        frameClk = 1'b0;
  logic        serData = 1'b0;
  logic [2:0]  fmtCode = 3'd5;
  logic [23:0] leftOut, rightOut;
  logic        sampleValid;

  int checks = 0;
  int fails  = 0;
  int validCount = 0;
  string curReq = "R1";
  logic [47:0] expQ[$];
  logic prevValid = 1'b0;
  logic [47:0] lastPair = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u_dut (
    .clk(clk), .rst(rst), .bitClk(bitClk), .frameClk(frameClk),
    .serData(serData), .fmtCode(fmtCode), .leftOut(leftOut),
    .rightOut(rightOut), .sampleValid(sampleValid)
  );

  task automatic checkVal(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (sampleValid) begin
        validCount++;
        checks++;
        if (prevValid) begin
          fails++;
          $display("FAIL R8 actual=strobe_wide expected=single_cycle");
        end else if (expQ.size() == 0) begin
          fails++;
          $display("FAIL %s actual=%h expected=no_strobe", curReq, {leftOut, rightOut});
        end else begin
          logic [47:0] e;
          e = expQ.pop_front();
          if ({leftOut, rightOut} !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", curReq, {leftOut, rightOut}, e);
          end
          lastPair = e;
        end
      end
      prevValid = sampleValid;
    end else prevValid = 1'b0;
  end

  function automatic int fmtN(input logic [2:0] f);
    return (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : 24;
  endfunction
  function automatic int fmtKind(input logic [2:0] f); // 0 lsb 1 msb 2 i2s
    if (f == 3'd0 || f == 3'd1 || f == 3'd4) return 0;
    if (f == 3'd2 || f == 3'd5) return 1;
    return 2;
  endfunction

  task automatic bitCycle(input logic d, input logic fr);
    @(negedge clk);
    frameClk = fr;
    serData  = d;
    repeat (BIT_HALF) @(negedge clk);
    bitClk = 1'b1;
    repeat (BIT_HALF) @(negedge clk);
    bitClk = 1'b0;
  endtask

  task automatic sendHalf(input logic lvl, input logic [23:0] raw, input int n,
                          input int kind, input int h, input int junkOnes);
    for (int p = 0; p < h; p++) begin
      logic b;
      b = junkOnes ? 1'b1 : 1'($urandom);
      if (kind == 1 && p < n) b = raw[n-1-p];
      if (kind == 2 && p >= 1 && p <= n) b = raw[n-p];
      if (kind == 0 && p >= h - n) b = raw[h-1-p];
      bitCycle(b, lvl);
    end
  endtask

  task automatic sendFrame(input logic [2:0] f, input logic [23:0] lRaw,
                           input logic [23:0] rRaw, input int h, input int junkOnes,
                           input bit push);
    int n, kind;
    logic leftLvl;
    logic [23:0] mask, l, r;
    n = fmtN(f); kind = fmtKind(f);
    leftLvl = (kind == 2) ? 1'b0 : 1'b1;
    mask = 24'hFFFFFF >> (24 - n);
    l = lRaw & mask; r = rRaw & mask;
    if (push) expQ.push_back({l << (24 - n), r << (24 - n)});
    sendHalf(leftLvl, l, n, kind, h, junkOnes);
    sendHalf(~leftLvl, r, n, kind, h, junkOnes);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runGroup(input logic [2:0] f, input int h, input int frames,
                          input int junkOnes, input string req);
    int kind;
    curReq = req;
    doReset();
    fmtCode = f;
    kind = fmtKind(f);
    for (int i = 0; i < 3; i++) bitCycle(1'($urandom), (kind == 2) ? 1'b1 : 1'b0);
    for (int i = 0; i < frames; i++) begin
      if (i == 0) sendFrame(f, 24'h000000, 24'hFFFFFF, h, junkOnes, 1'b1);
      else        sendFrame(f, 24'($urandom), 24'($urandom), h, junkOnes, 1'b1);
    end
    for (int i = 0; i < 2; i++) bitCycle(1'($urandom), (kind == 2) ? 1'b0 : 1'b1);
    repeat (20) @(negedge clk);
    checkVal({req, " queue drained"}, 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int vc;
    // R1: reset state
    repeat (3) @(negedge clk);
    checkVal("R1", {15'd0, sampleValid, leftOut, rightOut}, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checkVal("R1", {15'd0, sampleValid, leftOut, rightOut}, 64'd0);

    runGroup(3'd5, 32, 4, 0, "R3");      // MSB 24, 64 clocks
    runGroup(3'd2, 24, 3, 0, "R2");      // MSB 24, 48 clocks
    runGroup(3'd6, 32, 4, 0, "R4");      // I2S 24
    runGroup(3'd3, 32, 3, 0, "R2");      // I2S 24, other code
    runGroup(3'd4, 32, 3, 0, "R5");      // LSB 24
    runGroup(3'd4, 24, 2, 0, "R5");      // LSB 24, tight frame
    runGroup(3'd1, 32, 3, 0, "R6");      // LSB 20 padded
    runGroup(3'd0, 32, 3, 0, "R6");      // LSB 16 padded
    runGroup(3'd0, 16, 4, 0, "R9");      // 32-clock frame
    runGroup(3'd0, 32, 3, 1, "R7");      // junk all ones
    runGroup(3'd6, 32, 2, 1, "R7");

    // R1: reset mid-operation clears nonzero outputs
    curReq = "R1";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    checkVal("R1 midrun", {15'd0, sampleValid, leftOut, rightOut}, 64'd0);
    rst = 1'b0;

    // R10: reserved code, outputs hold
    runGroup(3'd5, 32, 2, 0, "R10");
    fmtCode = 3'd7;
    curReq = "R10";
    vc = validCount;
    for (int i = 0; i < 3; i++) sendFrame(3'd5, 24'($urandom), 24'($urandom), 32, 0, 1'b0);
    for (int i = 0; i < 2; i++) bitCycle(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    checkVal("R10 strobes", 64'(validCount - vc), 64'd0);
    checkVal("R10 hold", {16'd0, leftOut, rightOut}, {16'd0, lastPair});

    // R11: start mid-frame after reset
    curReq = "R11";
    @(negedge clk); rst = 1'b1; fmtCode = 3'd5;
    frameClk = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    vc = validCount;
    for (int i = 0; i < 10; i++) bitCycle(1'($urandom), 1'b1);
    for (int i = 0; i < 32; i++) bitCycle(1'($urandom), 1'b0);
    sendFrame(3'd5, 24'h123456, 24'hABCDEF, 32, 0, 1'b1);
    for (int i = 0; i < 2; i++) bitCycle(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    checkVal("R11 strobes", 64'(validCount - vc), 64'd1);
    checkVal("R11 queue", 64'(expQ.size()), 64'd0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule